// File: doc/BRIEF.md
# SS7 Link Repeat and Fill-In Controller

This block sits between a first-word-fall-through transmit FIFO and a bit-level HDLC framer. It turns the queued octets into a stream of bytes for the framer, and it adds two signalling-link behaviours. First, when the last message was short and the repeat control is held, that message is sent again and again. Each copy is a separate frame, so the framer gives every copy its own opening flag, FCS and closing flag. Second, when the FIFO runs dry and auto-fill is on, the block sends a chosen number of flag bytes and then a three-octet fill-in unit. That unit copies the sequence-number octets of the last data message.

The framer receives one byte per accepted transfer, using a valid/ready pair. Each byte is tagged in one of two ways. It is either an idle flag (0x7E), or a frame byte that carries start-of-frame and end-of-frame strobes. The framer computes the FCS and adds the closing flag after the byte marked end-of-frame. Bit stuffing and CRC are left to the framer.

Top module: `ss7_link_filler`

## Requirements
- R1: With the channel enabled and no other work pending, each output byte is 0x7E with `flag_o`=1 and both strobes low. This is also the state right after reset.
- R2: The FIFO head byte appears on `fifo_data_i` and is popped by `fifo_rd_o`. A data frame passes the FIFO bytes through in order. `sof_o` marks the first byte and `eof_o` marks the byte whose `fifo_eom_i` is 1. Every transmitted byte is popped exactly once. At least one flag byte comes between frames.
- R3: A data frame of fewer than 16 bytes arms the replay store. When `repeat_i`=1, an armed message is resent as complete frames, each copy followed by exactly one flag byte. A frame of 16 or more bytes disarms the store and is never resent.
- R4: Replay stops only at a frame boundary after `repeat_i` returns to 0. The copy in progress is always completed.
- R5: FIFO bytes that are present while a replay is starting or running are popped and discarded. They are never transmitted.
- R6: With `autofill_i`=1 and the FIFO empty, exactly N flag bytes come before each fill-in unit. `fill_cnt_i` codes 0, 1, 2 and 3 give N = 1, 2, 4 and 8.
- R7: A fill-in unit is three frame bytes: the stored backward octet, then the stored forward octet, then 0x00. `sof_o` is on the first byte and `eof_o` on the third. Before any data frame, both stored octets are 0x00.
- R8: The stored backward and forward octets are taken from bytes 0 and 1 of every data frame read from the FIFO.
- R9: When choosing the next frame at a flag byte, replay comes first, then FIFO data, then auto-fill, then plain flags.
- R10: While `en_i`=0, `valid_o` and `fifo_rd_o` stay 0. When the channel is enabled again, the output starts with an idle flag.
- R11: While `valid_o`=1 and `ready_i`=0, the output byte holds and nothing advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| repeat_i | input | 1 | Cyclic replay request |
| autofill_i | input | 1 | Enable fill-in units when idle |
| fill_cnt_i | input | 2 | Flag count code before each fill-in unit |
| fifo_empty_i | input | 1 | FIFO has no byte |
| fifo_data_i | input | 8 | FIFO head byte |
| fifo_eom_i | input | 1 | Head byte ends its message |
| fifo_rd_o | output | 1 | Pop FIFO head |
| ready_i | input | 1 | Framer accepts the current byte |
| valid_o | output | 1 | Output byte valid |
| data_o | output | 8 | Output byte |
| flag_o | output | 1 | Byte is an idle flag |
| sof_o | output | 1 | First byte of a frame |
| eof_o | output | 1 | Last byte of a frame |

## Verification
Some properties are checked by assertions on every cycle. A flag byte is always 0x7E with no strobe. The FIFO is never popped while empty. A disabled channel stays silent. Output bytes hold under backpressure. An armed store always has a legal length, and the sequence octets follow the byte just accepted. Other behaviour can only be shown by the bench scenarios. These are the exact number of flags between fill-in units for every count code, replay of a short message against a single send of a 16-byte one, completion of the last copy after repeat drops, discard of bytes written during replay, and the order of precedence among replay, data and fill.

// File: rtl/ss7_fill_pkg.sv
package ss7_fill_pkg;
  localparam logic [7:0] FLAG_BYTE = 8'h7E;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_REP,
    ST_FILL,
    ST_FISU
  } tx_state_e;

  function automatic logic [3:0] flag_total(input logic [1:0] code);
    return 4'd1 << code;
  endfunction
endpackage

// File: rtl/ss7_rep_buf.sv
module ss7_rep_buf #(
  parameter int DEPTH = 15,
  parameter int IW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          done_i,
  input  logic [IW-1:0] idx_i,
  input  logic [7:0]    data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [7:0]    rd_data_o,
  output logic [IW-1:0] len_o,
  output logic          armed_o
);
  logic [7:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (wr_i && idx_i == IW'(g)) mem_q[g] <= data_i;
    end
  end

  assign rd_data_o = (rd_idx_i < IW'(DEPTH)) ? mem_q[rd_idx_i] : '0;

  // idx_i saturates at DEPTH, so a long frame ends with idx_i == DEPTH
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
      len_o   <= '0;
    end else if (done_i) begin
      armed_o <= idx_i < IW'(DEPTH);
      len_o   <= IW'(idx_i + 1'b1);
    end
  end

  p_armed_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |-> (len_o != '0 && len_o <= IW'(DEPTH)));
endmodule

// File: rtl/ss7_seq_cap.sv
module ss7_seq_cap #(
  parameter int IW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [IW-1:0] idx_i,
  input  logic [7:0]    data_i,
  output logic [7:0]    bsn_o,
  output logic [7:0]    fsn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bsn_o <= '0;
      fsn_o <= '0;
    end else if (wr_i) begin
      if (idx_i == '0)     bsn_o <= data_i;
      if (idx_i == IW'(1)) fsn_o <= data_i;
    end
  end

  p_capture_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == '0) |=> bsn_o == $past(data_i));
endmodule

// File: rtl/ss7_flag_cnt.sv
module ss7_flag_cnt
  import ss7_fill_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       step_i,
  input  logic [1:0] code_i,
  output logic       one_o,
  output logic       last_o
);
  logic [3:0] cnt_q, total_q;

  assign one_o  = flag_total(code_i) == 4'd1;
  assign last_o = (cnt_q + 4'd1) == total_q;

  // count is latched at load so a code change cannot strand the run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      total_q <= 4'd1;
    end else if (load_i) begin
      cnt_q   <= 4'd1;
      total_q <= flag_total(code_i);
    end else if (step_i) begin
      cnt_q   <= cnt_q + 4'd1;
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> cnt_q < total_q);
endmodule

// File: rtl/ss7_link_filler.sv
module ss7_link_filler
  import ss7_fill_pkg::*;
#(
  parameter int REP_LIMIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       repeat_i,
  input  logic       autofill_i,
  input  logic [1:0] fill_cnt_i,
  input  logic       fifo_empty_i,
  input  logic [7:0] fifo_data_i,
  input  logic       fifo_eom_i,
  output logic       fifo_rd_o,
  input  logic       ready_i,
  output logic       valid_o,
  output logic [7:0] data_o,
  output logic       flag_o,
  output logic       sof_o,
  output logic       eof_o
);
  localparam int DEPTH = REP_LIMIT - 1;
  localparam int IW    = $clog2(REP_LIMIT);

  tx_state_e     st_q;
  logic [IW-1:0] idx_q;
  logic          fire, buf_wr, buf_done, go_rep;
  logic [7:0]    buf_rd, bsn, fsn;
  logic [IW-1:0] rep_len;
  logic          armed, fill_one, fill_last, fill_load, fill_step;

  assign fire     = valid_o && ready_i;
  assign go_rep   = armed && repeat_i;
  assign buf_wr   = en_i && st_q == ST_DATA && fire;
  assign buf_done = buf_wr && fifo_eom_i;
  assign fill_load = en_i && fire && st_q == ST_IDLE && !go_rep && fifo_empty_i
                     && autofill_i && !fill_one;
  assign fill_step = en_i && fire && st_q == ST_FILL && !fill_last;

  ss7_rep_buf #(.DEPTH(DEPTH), .IW(IW)) u_rep_buf (
    .clk_i, .rst_ni,
    .wr_i(buf_wr), .done_i(buf_done), .idx_i(idx_q), .data_i(fifo_data_i),
    .rd_idx_i(idx_q), .rd_data_o(buf_rd), .len_o(rep_len), .armed_o(armed)
  );

  ss7_seq_cap #(.IW(IW)) u_seq_cap (
    .clk_i, .rst_ni,
    .wr_i(buf_wr), .idx_i(idx_q), .data_i(fifo_data_i),
    .bsn_o(bsn), .fsn_o(fsn)
  );

  ss7_flag_cnt u_flag_cnt (
    .clk_i, .rst_ni,
    .load_i(fill_load), .step_i(fill_step), .code_i(fill_cnt_i),
    .one_o(fill_one), .last_o(fill_last)
  );

  always_comb begin
    valid_o   = 1'b0;
    data_o    = FLAG_BYTE;
    flag_o    = 1'b0;
    sof_o     = 1'b0;
    eof_o     = 1'b0;
    fifo_rd_o = 1'b0;
    if (en_i) begin
      unique case (st_q)
        ST_IDLE: begin
          valid_o   = 1'b1;
          flag_o    = 1'b1;
          fifo_rd_o = go_rep && !fifo_empty_i;
        end
        ST_FILL: begin
          valid_o = 1'b1;
          flag_o  = 1'b1;
        end
        ST_DATA: begin
          valid_o   = !fifo_empty_i;
          data_o    = fifo_data_i;
          sof_o     = !fifo_empty_i && idx_q == '0;
          eof_o     = !fifo_empty_i && fifo_eom_i;
          fifo_rd_o = !fifo_empty_i && ready_i;
        end
        ST_REP: begin
          valid_o   = 1'b1;
          data_o    = buf_rd;
          sof_o     = idx_q == '0;
          eof_o     = idx_q == IW'(rep_len - 1'b1);
          fifo_rd_o = !fifo_empty_i;  // discard writes made during replay
        end
        ST_FISU: begin
          valid_o = 1'b1;
          data_o  = (idx_q == '0) ? bsn : (idx_q == IW'(1)) ? fsn : 8'h00;
          sof_o   = idx_q == '0;
          eof_o   = idx_q == IW'(2);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else if (!en_i) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else if (fire) begin
      unique case (st_q)
        ST_IDLE: begin
          idx_q <= '0;
          if (go_rep)            st_q <= ST_REP;
          else if (!fifo_empty_i) st_q <= ST_DATA;
          else if (autofill_i)   st_q <= fill_one ? ST_FISU : ST_FILL;
        end
        ST_FILL: if (fill_last) st_q <= ST_FISU;
        ST_DATA: begin
          if (eof_o)                    st_q  <= ST_IDLE;
          else if (idx_q < IW'(DEPTH))  idx_q <= idx_q + 1'b1;
        end
        ST_REP, ST_FISU: begin
          if (eof_o) st_q  <= ST_IDLE;
          else       idx_q <= idx_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_flag_byte_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> (data_o == FLAG_BYTE && !sof_o && !eof_o));

  p_read_nonempty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |-> !fifo_empty_i);

  p_disabled_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!valid_o && !fifo_rd_o));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_o && !ready_i && st_q != ST_DATA) |=> (!en_i || $stable(data_o)));
endmodule

// File: tb/ss7_link_filler_tb_top.sv
module ss7_link_filler_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, en, rep, af, ready;
  logic [1:0] code;
  logic fifo_empty, fifo_eom, fifo_rd;
  logic [7:0] fifo_data, odata;
  logic valid, flag, sof, eof;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ss7_link_filler dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .repeat_i(rep), .autofill_i(af),
    .fill_cnt_i(code), .fifo_empty_i(fifo_empty), .fifo_data_i(fifo_data),
    .fifo_eom_i(fifo_eom), .fifo_rd_o(fifo_rd), .ready_i(ready),
    .valid_o(valid), .data_o(odata), .flag_o(flag), .sof_o(sof), .eof_o(eof)
  );

  // FIFO model, head byte visible
  logic [8:0] fmem [0:255];
  int wp = 0, rp = 0;
  assign fifo_empty = (wp == rp);
  assign fifo_data  = fmem[rp[7:0]][7:0];
  assign fifo_eom   = fmem[rp[7:0]][8];
  always @(posedge clk) if (fifo_rd) rp <= rp + 1;

  task automatic push(input logic [7:0] b, input bit last);
    fmem[wp[7:0]] = {last, b};
    wp++;
  endtask

  // accepted-byte log
  logic [7:0] lg_d [0:1023];
  bit lg_f [0:1023];
  bit lg_s [0:1023];
  bit lg_e [0:1023];
  int lg_n = 0;
  always @(negedge clk) begin
    if (rst_n && valid && ready && lg_n < 1024) begin
      lg_d[lg_n] = odata; lg_f[lg_n] = flag; lg_s[lg_n] = sof; lg_e[lg_n] = eof;
      lg_n++;
    end
  end

  int total = 0, bad = 0;
  int nfr, nfull, bad_form, tail_fl;
  int fr_st [0:63];
  int fr_len [0:63];
  int fr_gap [0:63];
  logic [7:0] exp_b [0:15];
  int exp_len;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic parse();
    bit in_fr = 0;
    int gap = 0;
    nfr = 0; bad_form = 0;
    for (int i = 0; i < lg_n; i++) begin
      if (lg_f[i]) begin
        if (in_fr) bad_form++;
        in_fr = 0;
        gap++;
      end else begin
        if (lg_s[i]) begin
          if (in_fr) bad_form++;
          in_fr = 1;
          if (nfr < 64) begin fr_st[nfr] = i; fr_len[nfr] = 0; fr_gap[nfr] = gap; end
          nfr++;
          gap = 0;
        end else if (!in_fr) bad_form++;
        if (in_fr && nfr > 0 && nfr <= 64) fr_len[nfr-1]++;
        if (lg_e[i]) in_fr = 0;
      end
    end
    tail_fl = gap;
    nfull = (nfr > 64 ? 64 : nfr) - (in_fr ? 1 : 0);
  endtask

  task automatic chk_frames(input string req, input int from);
    for (int i = from; i < nfull; i++) begin
      chk(fr_len[i] == exp_len, req, fr_len[i], exp_len);
      if (fr_len[i] == exp_len)
        for (int j = 0; j < exp_len; j++)
          chk(lg_d[fr_st[i]+j] == exp_b[j], req, lg_d[fr_st[i]+j], exp_b[j]);
    end
  endtask

  task automatic chk_gaps(input string req, input int from, input int n);
    for (int i = from; i < nfull; i++) chk(fr_gap[i] == n, req, fr_gap[i], n);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog act=1 exp=0");
    finish_run();
  end

  initial begin
    logic [7:0] held;
    int rp0;
    rst_n = 0; en = 1; rep = 0; af = 0; code = 2'd0; ready = 1;
    tick(3);
    @(negedge clk);
    chk(valid && flag && odata == 8'h7E && !sof && !eof && !fifo_rd, "R1 reset", odata, 8'h7E);
    @(posedge clk); #1;
    rst_n = 1;

    // R1: idle flags
    lg_n = 0; tick(20); parse();
    chk(nfr == 0 && bad_form == 0, "R1 idle frames", nfr, 0);
    chk(lg_n >= 19, "R1 idle flow", lg_n, 20);

    // R7: fill-in before any data carries zeros, N=1
    af = 1; code = 2'd0;
    lg_n = 0; tick(24); parse();
    chk(nfull >= 3 && bad_form == 0, "R7 fisu count", nfull, 3);
    exp_b[0] = 8'h00; exp_b[1] = 8'h00; exp_b[2] = 8'h00; exp_len = 3;
    chk_frames("R7 zero fisu", 0);
    chk_gaps("R6 gap N=1", 1, 1);
    af = 0; tick(6);

    // R2, R8: plain data frame
    lg_n = 0;
    push(8'h11, 0); push(8'h22, 0); push(8'h33, 0); push(8'h44, 0); push(8'h55, 1);
    tick(20); parse();
    chk(nfull == 1 && bad_form == 0, "R2 one frame", nfull, 1);
    exp_b[0] = 8'h11; exp_b[1] = 8'h22; exp_b[2] = 8'h33; exp_b[3] = 8'h44; exp_b[4] = 8'h55;
    exp_len = 5;
    chk_frames("R2 data", 0);
    chk(fr_gap[0] >= 1 && tail_fl >= 1, "R2 flag separation", fr_gap[0], 1);
    chk(rp == wp, "R2 popped once", rp, wp);

    // R3, R4, R5: short message replay with junk written meanwhile
    lg_n = 0;
    push(8'hA1, 0); push(8'hB2, 0); push(8'hC3, 1);
    tick(2);
    rep = 1;
    tick(6);
    push(8'hEE, 0); push(8'hEF, 1);
    tick(20);
    rep = 0;
    tick(12); parse();
    chk(bad_form == 0, "R4 complete copies", bad_form, 0);
    chk(nfull >= 5, "R3 repeated", nfull, 5);
    exp_b[0] = 8'hA1; exp_b[1] = 8'hB2; exp_b[2] = 8'hC3; exp_len = 3;
    chk_frames("R3 R5 replay content", 0);
    chk_gaps("R3 single flag", 1, 1);
    chk(tail_fl >= 5, "R4 stop after clear", tail_fl, 5);
    chk(rp == wp, "R5 junk drained", rp, wp);

    // R3: 16-byte frame never repeats
    lg_n = 0;
    for (int i = 0; i < 16; i++) push(8'(i * 7 + 1), i == 15);
    tick(3);
    rep = 1;
    tick(40);
    rep = 0;
    tick(3); parse();
    chk(nfull == 1 && nfr == 1, "R3 long no replay", nfr, 1);
    exp_len = 16;
    for (int i = 0; i < 16; i++) exp_b[i] = 8'(i * 7 + 1);
    chk_frames("R3 long content", 0);

    // R9: replay beats fresh FIFO data
    lg_n = 0;
    push(8'hC1, 0); push(8'hC2, 1);
    tick(10);
    rep = 1;
    push(8'hD1, 0); push(8'hD2, 0); push(8'hD3, 1);
    tick(12);
    rep = 0;
    tick(8); parse();
    chk(nfull >= 3 && bad_form == 0, "R9 replay count", nfull, 3);
    exp_b[0] = 8'hC1; exp_b[1] = 8'hC2; exp_len = 2;
    chk_frames("R9 replay over data", 0);
    chk(rp == wp, "R5 new data discarded", rp, wp);

    // R9 data before fill, R6/R7/R8 sweep of count codes
    lg_n = 0;
    push(8'h5A, 0); push(8'hC3, 0); push(8'h99, 1);
    af = 1; code = 2'd0;
    tick(30); parse();
    chk(nfull >= 3 && fr_len[0] == 3 && lg_d[fr_st[0]] == 8'h5A, "R9 data before fill",
        lg_d[fr_st[0]], 8'h5A);
    exp_b[0] = 8'h5A; exp_b[1] = 8'hC3; exp_b[2] = 8'h00; exp_len = 3;
    chk_frames("R8 fisu recapture", 1);
    chk_gaps("R6 code0", 1, 1);
    for (int k = 1; k < 4; k++) begin
      do @(negedge clk); while (!flag);
      @(posedge clk); #1;
      code = 2'(k);
      lg_n = 0;
      tick(70); parse();
      chk(nfull >= 3 && bad_form == 0, "R6 fisu runs", nfull, 3);
      exp_b[2] = 8'h00;
      chk_frames("R7 fisu content", 0);
      chk_gaps("R6 flag count", 1, 1 << k);
    end
    af = 0; tick(12);

    // R11: backpressure inside a data frame
    lg_n = 0;
    push(8'h71, 0); push(8'h72, 0); push(8'h73, 0); push(8'h74, 1);
    tick(3);
    ready = 0;
    rp0 = rp;
    @(negedge clk);
    held = odata;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(odata == held && !fifo_rd, "R11 hold", odata, held);
    end
    chk(rp == rp0, "R11 no pop", rp, rp0);
    @(posedge clk); #1;
    ready = 1;
    tick(15); parse();
    exp_b[0] = 8'h71; exp_b[1] = 8'h72; exp_b[2] = 8'h73; exp_b[3] = 8'h74; exp_len = 4;
    chk(nfull == 1, "R11 frame intact", nfull, 1);
    chk_frames("R11 content", 0);

    // R10: disabled channel
    en = 0;
    rp0 = rp;
    push(8'h81, 0); push(8'h82, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!valid && !fifo_rd, "R10 quiet", valid, 0);
    end
    chk(rp == rp0, "R10 no pop", rp, rp0);
    @(posedge clk); #1;
    lg_n = 0;
    en = 1;
    tick(10); parse();
    chk(lg_n > 0 && lg_f[0], "R10 restart flag", lg_f[0], 1);
    exp_b[0] = 8'h81; exp_b[1] = 8'h82; exp_len = 2;
    chk(nfull == 1, "R10 frame after enable", nfull, 1);
    chk_frames("R10 content", 0);

    finish_run();
  end
endmodule